// File: doc/BRIEF.md
# Script DMA Transfer Chunker

This block performs a single block-move step for a script-driven SCSI DMA engine. It keeps three counters: the next memory address, the byte count still owed to the current script instruction, and a running total of bytes moved on the SCSI side. When the sequencer issues a start, it also supplies the number of bytes the device buffer holds and the direction. The block then moves the smaller of the two counts through a word-wide request/done memory port and updates all counters as each beat completes.

At the end of the step the block gives a single-cycle completion pulse with at most one outcome. If the device buffer has run dry, it signals *drained* together with the direction, so the device side can fetch or accept the next buffer. If device bytes are still waiting, it signals *resume*, and the script sequencer continues with its next instruction. A start with an empty device buffer does no work and gives a bare completion. Memory beats carry up to `BB` bytes. A beat never crosses a word boundary, and byte enables mark partial beats at unaligned starts and short tails.

Top module: `dma_chunker`

## Requirements
- R1: After reset the block is idle: busy, mem_req, done, drained and resume are low, and cur_addr, cur_count, total_bytes and dev_left are all zero.
- R2: A cfg_load pulse while idle sets cur_addr to cfg_addr and cur_count to cfg_count on the next clock. A cfg_load pulse while busy has no effect.
- R3: A start with dev_len equal to zero raises done exactly one cycle later. No memory request is made, drained and resume stay low, and no counter changes.
- R4: The bytes moved in one step equal the smaller of cur_count and dev_len, both sampled at start.
- R5: Each beat moves min(BB - cur_addr mod BB, bytes left in the step) bytes. mem_addr is cur_addr rounded down to a BB multiple. mem_be bit i enables the byte at mem_addr + i, and the set bits run contiguously from bit cur_addr mod BB.
- R6: Each accepted beat (mem_req and mem_done both high at a clock edge) of n bytes adds n to cur_addr, subtracts n from cur_count, and subtracts n from dev_left. dev_left is loaded with dev_len at start.
- R7: dir_out = 1 selects a memory read (mem_we low, data out to the device). dir_out = 0 selects a memory write (mem_we high, data in from the device). The direction is captured at start and held for the whole step.
- R8: done is a one-cycle pulse in the cycle after the last beat is accepted, or in the cycle after start if the step moves no bytes. When done is high, drained is high if dev_left is zero and dev_len was non-zero, and drain_out then repeats the captured direction. Otherwise resume is high if dev_left is non-zero, and this includes a step where cur_count was zero.
- R9: start is ignored while busy is high.
- R10: Each accepted beat of n bytes adds n to total_bytes, which wraps modulo 2^TW.
- R11: Once raised, mem_req stays high, with mem_addr and mem_be unchanged, until mem_done is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_load | input | 1 | Load address and script count (honoured only when idle) |
| cfg_addr | input | AW | Next-address value to load |
| cfg_count | input | CW | Script byte count to load |
| start | input | 1 | Start one step (honoured only when idle) |
| dir_out | input | 1 | 1: memory read toward device; 0: memory write from device |
| dev_len | input | LW | Bytes available from the device buffer, sampled at start |
| busy | output | 1 | Step in progress |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | Beat writes memory |
| mem_addr | output | AW | Word-aligned beat address |
| mem_be | output | BB | Byte enables of the beat |
| mem_done | input | 1 | Memory accepted the current beat |
| done | output | 1 | One-cycle completion pulse |
| drained | output | 1 | Device buffer emptied (with done) |
| resume | output | 1 | Device data remain, continue the script (with done) |
| drain_out | output | 1 | Direction of the drained buffer |
| cur_addr | output | AW | Next memory address |
| cur_count | output | CW | Remaining script byte count |
| total_bytes | output | TW | Cumulative SCSI byte counter |
| dev_left | output | LW | Remaining device-buffer bytes |

## Verification
The bench builds the block with AW=16, CW=10, LW=10 and TW=12. With these sizes, a few steps of 1000 bytes carry the 12-bit running total past 4096, so its wrap is reached in a few thousand cycles. Unaligned start addresses, script counts that are smaller than, equal to and larger than the device length, zero counts on either side, and a memory port that stalls a varying number of cycles all occur within the same short run. A behavioural model, compared on every clock, tracks counters, beat lanes and the outcome flags.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MOVE = 2'd1,
    ST_FIN  = 2'd2
  } dmc_state_e;
endpackage

// File: rtl/dmc_rst_sync.sv
module dmc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign srst_n = s2_q;
endmodule

// File: rtl/dmc_beat_calc.sv
// Bytes and lane enables of one memory beat, never crossing a word boundary.
module dmc_beat_calc #(
  parameter int BB = 4,
  parameter int MW = 24,
  localparam int OFFW = $clog2(BB)
) (
  input  logic [OFFW-1:0] off,
  input  logic [MW-1:0]   left,
  output logic [OFFW:0]   nb,
  output logic [BB-1:0]   be
);
  logic [OFFW:0]   room;
  logic [OFFW+1:0] lo, hi;

  always_comb begin
    room = (OFFW+1)'(BB) - {1'b0, off};
    if (left < MW'(room)) nb = left[OFFW:0];
    else                  nb = room;
    lo = {2'b00, off};
    hi = {2'b00, off} + {1'b0, nb};
  end

  for (genvar gi = 0; gi < BB; gi++) begin : g_lane
    localparam logic [OFFW+1:0] IDX = (OFFW+2)'(gi);
    assign be[gi] = (IDX >= lo) && (IDX < hi);
  end
endmodule

// File: rtl/dmc_regs.sv
// Address, script count and cumulative byte counter.
module dmc_regs #(
  parameter int AW = 32,
  parameter int CW = 24,
  parameter int TW = 32,
  parameter int NW = 3
) (
  input  logic          clk,
  input  logic          srst_n,
  input  logic          load,
  input  logic [AW-1:0] ld_addr,
  input  logic [CW-1:0] ld_count,
  input  logic          step,
  input  logic [NW-1:0] nb,
  output logic [AW-1:0] addr_q,
  output logic [CW-1:0] cnt_q,
  output logic [TW-1:0] tot_q
);
  logic [AW-1:0] addr_d;
  logic [CW-1:0] cnt_d;
  logic [TW-1:0] tot_d;
  logic          en_ac, en_t;

  always_comb begin
    addr_d = addr_q;
    cnt_d  = cnt_q;
    tot_d  = tot_q;
    en_ac  = 1'b0;
    en_t   = 1'b0;
    if (load) begin
      addr_d = ld_addr;
      cnt_d  = ld_count;
      en_ac  = 1'b1;
    end else if (step) begin
      addr_d = addr_q + AW'(nb);
      cnt_d  = cnt_q - CW'(nb);
      tot_d  = tot_q + TW'(nb);
      en_ac  = 1'b1;
      en_t   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (en_ac) begin
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)   tot_q <= '0;
    else if (en_t) tot_q <= tot_d;
  end
endmodule

// File: rtl/dmc_ctrl.sv
// Step sequencing: chunk sizing, device-length tracking and outcome.
module dmc_ctrl
  import dmc_pkg::*;
#(
  parameter int CW = 24,
  parameter int LW = 24,
  parameter int MW = 24,
  parameter int NW = 3
) (
  input  logic          clk,
  input  logic          srst_n,
  input  logic          start,
  input  logic          dir_out,
  input  logic [LW-1:0] dev_len,
  input  logic [CW-1:0] cnt,
  input  logic          mem_done,
  input  logic [NW-1:0] nb,
  output logic [MW-1:0] left_q,
  output logic [LW-1:0] dev_q,
  output logic          busy,
  output logic          mem_req,
  output logic          step,
  output logic          done,
  output logic          drained,
  output logic          resume,
  output logic          dir_q
);
  dmc_state_e    state_q, state_d;
  logic [LW-1:0] dev_d;
  logic [MW-1:0] left_d, first_len, cnt_ext, dev_ext;
  logic          dir_d, zero_q, zero_d, en_ctx;

  assign cnt_ext   = MW'(cnt);
  assign dev_ext   = MW'(dev_len);
  assign first_len = (cnt_ext < dev_ext) ? cnt_ext : dev_ext;

  always_comb begin
    state_d = state_q;
    dev_d   = dev_q;
    left_d  = left_q;
    dir_d   = dir_q;
    zero_d  = zero_q;
    en_ctx  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (start) begin
        en_ctx  = 1'b1;
        dev_d   = dev_len;
        left_d  = first_len;
        dir_d   = dir_out;
        zero_d  = (dev_len == '0);
        state_d = (first_len == '0) ? ST_FIN : ST_MOVE;
      end
      ST_MOVE: if (mem_done) begin
        en_ctx = 1'b1;
        dev_d  = dev_q - LW'(nb);
        left_d = left_q - MW'(nb);
        if (left_q == MW'(nb)) state_d = ST_FIN;
      end
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      dev_q  <= '0;
      left_q <= '0;
      dir_q  <= 1'b0;
      zero_q <= 1'b0;
    end else if (en_ctx) begin
      dev_q  <= dev_d;
      left_q <= left_d;
      dir_q  <= dir_d;
      zero_q <= zero_d;
    end
  end

  assign busy    = (state_q != ST_IDLE);
  assign mem_req = (state_q == ST_MOVE);
  assign step    = mem_req & mem_done;
  assign done    = (state_q == ST_FIN);
  assign drained = done & ~zero_q & (dev_q == '0);
  assign resume  = done & (dev_q != '0);
endmodule

// File: rtl/dma_chunker.sv
module dma_chunker #(
  parameter int AW = 32,
  parameter int CW = 24,
  parameter int LW = 24,
  parameter int TW = 32,
  parameter int BB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [AW-1:0] cfg_addr,
  input  logic [CW-1:0] cfg_count,
  input  logic          start,
  input  logic          dir_out,
  input  logic [LW-1:0] dev_len,
  output logic          busy,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [BB-1:0] mem_be,
  input  logic          mem_done,
  output logic          done,
  output logic          drained,
  output logic          resume,
  output logic          drain_out,
  output logic [AW-1:0] cur_addr,
  output logic [CW-1:0] cur_count,
  output logic [TW-1:0] total_bytes,
  output logic [LW-1:0] dev_left
);
  localparam int OFFW = $clog2(BB);
  localparam int NW   = OFFW + 1;
  localparam int MW   = (CW > LW) ? CW : LW;

  logic          srst_n, step, dir_q;
  logic [NW-1:0] nb;
  logic [MW-1:0] left_q;

  dmc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  dmc_regs #(.AW(AW), .CW(CW), .TW(TW), .NW(NW)) u_regs (
    .clk(clk), .srst_n(srst_n),
    .load(cfg_load & ~busy), .ld_addr(cfg_addr), .ld_count(cfg_count),
    .step(step), .nb(nb),
    .addr_q(cur_addr), .cnt_q(cur_count), .tot_q(total_bytes)
  );

  dmc_beat_calc #(.BB(BB), .MW(MW)) u_beat (
    .off(cur_addr[OFFW-1:0]), .left(left_q), .nb(nb), .be(mem_be)
  );

  dmc_ctrl #(.CW(CW), .LW(LW), .MW(MW), .NW(NW)) u_ctrl (
    .clk(clk), .srst_n(srst_n),
    .start(start), .dir_out(dir_out), .dev_len(dev_len),
    .cnt(cur_count), .mem_done(mem_done), .nb(nb),
    .left_q(left_q), .dev_q(dev_left),
    .busy(busy), .mem_req(mem_req), .step(step),
    .done(done), .drained(drained), .resume(resume), .dir_q(dir_q)
  );

  assign mem_we    = ~dir_q;
  assign drain_out = dir_q;
  assign mem_addr  = {cur_addr[AW-1:OFFW], {OFFW{1'b0}}};
endmodule

// File: rtl/dmc_checker.sv
module dmc_checker #(
  parameter int AW = 32,
  parameter int CW = 24,
  parameter int LW = 24,
  parameter int TW = 32,
  parameter int BB = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_load,
  input logic          start,
  input logic          busy,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [BB-1:0] mem_be,
  input logic          mem_done,
  input logic          done,
  input logic          drained,
  input logic          resume,
  input logic [AW-1:0] cur_addr,
  input logic [CW-1:0] cur_count,
  input logic [TW-1:0] total_bytes
);
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_done |=> mem_req && $stable(mem_addr) && $stable(mem_be));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r8_outcome_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    (drained || resume) |-> done);

  a_r8_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    drained |-> !resume);

  a_r5_lanes_present: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_be != '0);

  a_r6_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_done |=>
      cur_count == CW'($past(cur_count) - CW'($countones($past(mem_be)))));

  a_r10_total_step: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_done |=>
      total_bytes == TW'($past(total_bytes) + TW'($countones($past(mem_be)))));

  a_r7_dir_steady: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req || $stable(mem_we));

  a_r2_load_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy && cfg_load && !mem_done |=> $stable(cur_addr) && $stable(cur_count));
endmodule

bind dma_chunker dmc_checker #(.AW(AW), .CW(CW), .LW(LW), .TW(TW), .BB(BB)) u_chk (.*);

// File: tb/tb_dma_chunker.sv
module tb_dma_chunker;
  localparam int AW = 16, CW = 10, LW = 10, TW = 12, BB = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, cfg_load, start, dir_out, mem_done;
  logic [AW-1:0] cfg_addr;
  logic [CW-1:0] cfg_count;
  logic [LW-1:0] dev_len;
  logic busy, mem_req, mem_we, done, drained, resume, drain_out;
  logic [AW-1:0] mem_addr, cur_addr;
  logic [BB-1:0] mem_be;
  logic [CW-1:0] cur_count;
  logic [TW-1:0] total_bytes;
  logic [LW-1:0] dev_left;

  dma_chunker #(.AW(AW), .CW(CW), .LW(LW), .TW(TW), .BB(BB)) dut (.*);

  int checks = 0, fails = 0;
  bit live = 0, finished = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  int m_st, m_addr, m_cnt, m_tot, m_dev, m_left, m_dir, m_zero;
  int beats = 0, moved = 0, n_done = 0, n_drain = 0, n_resume = 0;

  function automatic int beat_n(int a, int l);
    int room = BB - (a % BB);
    return (l < room) ? l : room;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_addr = 0; m_cnt = 0; m_tot = 0;
      m_dev = 0; m_left = 0; m_dir = 0; m_zero = 0;
    end else begin
      if (mem_req && mem_done) begin
        beats++;
        moved += $countones(mem_be);
      end
      case (m_st)
        0: begin
          if (start) begin
            m_dev  = int'(dev_len);
            m_left = (m_cnt < m_dev) ? m_cnt : m_dev;
            m_dir  = int'(dir_out);
            m_zero = (m_dev == 0);
            m_st   = (m_left == 0) ? 2 : 1;
          end
          if (cfg_load) begin
            m_addr = int'(cfg_addr);
            m_cnt  = int'(cfg_count);
          end
        end
        1: if (mem_done) begin
          int n;
          n = beat_n(m_addr, m_left);
          m_addr = (m_addr + n) % (1 << AW);
          m_cnt  = m_cnt - n;
          m_tot  = (m_tot + n) % (1 << TW);
          m_dev  = m_dev - n;
          m_left = m_left - n;
          if (m_left == 0) m_st = 2;
        end
        default: m_st = 0;
      endcase
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && live && !finished) begin
      chk("R9 busy", busy, m_st != 0);
      chk("R11 mem_req", mem_req, m_st == 1);
      if (m_st == 1) begin
        int n;
        n = beat_n(m_addr, m_left);
        chk("R5 mem_addr", mem_addr, m_addr & ~(BB - 1));
        chk("R5 mem_be", mem_be, ((1 << n) - 1) << (m_addr % BB));
        chk("R7 mem_we", mem_we, m_dir == 0);
      end
      chk("R6 cur_addr", cur_addr, m_addr);
      chk("R6 cur_count", cur_count, m_cnt);
      chk("R6 dev_left", dev_left, m_dev);
      chk("R10 total_bytes", total_bytes, m_tot);
      chk("R8 done", done, m_st == 2);
      chk("R8 drained", drained, (m_st == 2) && !m_zero && (m_dev == 0));
      chk("R8 resume", resume, (m_st == 2) && (m_dev != 0));
      if (drained) chk("R8 drain_out", drain_out, m_dir);
      if (done) n_done++;
      if (drained) n_drain++;
      if (resume) n_resume++;
    end
  end

  // memory responder with varying stall
  int wcnt = 0, pat = 0;
  always @(negedge clk) begin
    if (!rst_n) mem_done <= 1'b0;
    else if (mem_done) mem_done <= 1'b0;
    else if (mem_req) begin
      if (wcnt == 0) begin
        mem_done <= 1'b1;
        pat = (pat + 1) % 3;
        wcnt = pat;
      end else wcnt--;
    end
  end

  task automatic load(int a, int c);
    @(negedge clk);
    cfg_load = 1'b1; cfg_addr = AW'(a); cfg_count = CW'(c);
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic go(bit d, int len);
    @(negedge clk);
    start = 1'b1; dir_out = d; dev_len = LW'(len);
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected<150000", cyc);
      summary();
    end
  end

  initial begin
    int b0, m0, d0, r0, t0;
    rst_n = 1'b0; cfg_load = 1'b0; start = 1'b0; dir_out = 1'b0;
    cfg_addr = '0; cfg_count = '0; dev_len = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 busy", busy, 0);       chk("R1 mem_req", mem_req, 0);
    chk("R1 done", done, 0);       chk("R1 cur_addr", cur_addr, 0);
    chk("R1 cur_count", cur_count, 0); chk("R1 total", total_bytes, 0);
    chk("R1 dev_left", dev_left, 0);
    live = 1;

    // R2 load while idle
    load('h100, 20);
    chk("R2 addr", cur_addr, 'h100);
    chk("R2 count", cur_count, 20);

    // R4/R8 device shorter than script: drained
    m0 = moved; d0 = n_drain;
    go(1, 8);
    chk("R4 moved", moved - m0, 8);
    chk("R8 drained seen", n_drain - d0, 1);
    chk("R6 dev_left", dev_left, 0);

    // R4/R8 script shorter than device: resume
    load('h180, 5);
    m0 = moved; r0 = n_resume;
    go(0, 12);
    chk("R4 moved", moved - m0, 5);
    chk("R8 resume seen", n_resume - r0, 1);
    chk("R6 dev_left", dev_left, 7);

    // R5 unaligned start and short tail: lanes 1,4,4,1
    load('h203, 10);
    b0 = beats;
    go(0, 10);
    chk("R5 beats", beats - b0, 4);
    chk("R5 end addr", cur_addr, 'h20D);

    // R3 empty device buffer
    load('h300, 9);
    b0 = beats; d0 = n_drain; r0 = n_resume;
    go(1, 0);
    chk("R3 beats", beats - b0, 0);
    chk("R3 no outcome", (n_drain - d0) + (n_resume - r0), 0);
    chk("R3 addr", cur_addr, 'h300);
    chk("R3 count", cur_count, 9);

    // R8 zero script count with device data: resume, no data
    load('h310, 0);
    m0 = moved; r0 = n_resume;
    go(1, 6);
    chk("R8 zero count moved", moved - m0, 0);
    chk("R8 zero count resume", n_resume - r0, 1);

    // R9 start and R2 load while busy are ignored
    load('h400, 40);
    d0 = n_done; m0 = moved;
    @(negedge clk);
    start = 1'b1; dir_out = 1'b1; dev_len = LW'(40);
    @(negedge clk);
    start = 1'b0;
    repeat (2) @(negedge clk);
    start = 1'b1; dev_len = LW'(3); dir_out = 1'b0;
    @(negedge clk);
    start = 1'b0; cfg_load = 1'b1; cfg_addr = '0; cfg_count = CW'(1);
    @(negedge clk);
    cfg_load = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);
    chk("R9 moved", moved - m0, 40);
    chk("R9 one done", n_done - d0, 1);
    chk("R2 busy load ignored", cur_addr, 'h428);

    // R10 cumulative counter wrap
    t0 = int'(total_bytes);
    for (int k = 0; k < 5; k++) begin
      load(k * 'h40, 1000);
      go(k[0], 1000);
    end
    chk("R10 wrap", total_bytes, (t0 + 5000) % (1 << TW));

    repeat (3) @(negedge clk);
    summary();
  end
endmodule